// File: doc/BRIEF.md
# Task Control Register with AXI4-Lite Access

This block is a small AXI4-Lite slave that owns one control word at offset 0x0 and uses it to run a compute core through a start/done/idle/ready handshake. Software sets a start flag to launch a task. It then polls the same word until a sticky completion flag appears. Reading that word clears the completion flag. An auto-relaunch flag lets the core run back to back without software stepping in after each task.

A build parameter selects the variant. In handshake mode the word reflects live state. In free-running mode the word always reads as 0x06, writes change nothing visible, and the start output is held high whenever reset is low, so the core runs from reset onward. Address and data arrive on independent channels in either order. Only the word at offset 0x0 is mapped. Every other offset answers with an error response.

Top module: `task_ctl_axil`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the start, done and auto-relaunch flags are 0, `core_start` is 0 (handshake mode), and `s_bvalid` and `s_rvalid` are 0.
- R2: The control word decodes as follows. Bit 7 is auto-relaunch. Bit 3 is the live `core_ready` input. Bit 2 is the live `core_idle` input. Bit 1 is done. Bit 0 is start. Every other bit reads 0, and an access is mapped when address bits [ADDR_W-1:2] are all zero.
- R3: A mapped write with `s_wstrb[0]`=1 and data bit 0 = 1 sets start, which drives `core_start` high. Writing 0 to bit 0 leaves start unchanged. A register change becomes visible in the same cycle `s_bvalid` rises.
- R4: Start clears one cycle after a clock edge at which start and `core_ready` are both 1, unless a new set happens at that same edge.
- R5: Done sets on a clock edge with `core_done`=1 and holds until a mapped read address is accepted. That read returns the pre-edge value. If `core_done` coincides with the clearing read, done stays 1.
- R6: Bit 7 is written from data bit 7 under `s_wstrb[0]`. While it is 1, a `core_done` edge sets start.
- R7: A mapped write with `s_wstrb[0]`=0 changes no flag.
- R8: Address and data are accepted in either order or together. There is exactly one write response per write, and `s_bvalid` with `s_bresp` holds until `s_bready`.
- R9: An unmapped access returns SLVERR (2'b10) and mapped ones return OKAY (2'b00). An unmapped write changes nothing. An unmapped read returns 0 and does not clear done.
- R10: In free-running mode every OKAY read returns 0x06, writes have no visible effect, and `core_start` is 1 whenever `rst` is 0.
- R11: `s_rvalid`, `s_rdata` and `s_rresp` hold stable until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| core_start | output | 1 | Task start request to the core |
| core_done | input | 1 | Core reports task completion |
| core_idle | input | 1 | Core is idle |
| core_ready | input | 1 | Core accepts a start |

## Verification
Assertions check several rules on every cycle:
- response holding on both channels;
- start clearing after the handshake;
- done setting and staying sticky;
- zero reserved bits;
- the zero data of error reads;
- the fixed word of the free-running variant.

Only the bench's scenarios can show the rest. That covers the write ordering cases, strobe masking, read-to-clear including the coincident set, auto-relaunch, and unmapped accesses leaving the word intact. The bench shows these by comparing the response data and `core_start` against a behavioural model on every clock.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
    // Bit positions of the control word (software decodes these).
    localparam int START_BIT = 0;
    localparam int DONE_BIT  = 1;
    localparam int IDLE_BIT  = 2;
    localparam int READY_BIT = 3;
    localparam int AUTO_BIT  = 7;
    localparam int CTRL_BITS = 8;

    localparam logic [CTRL_BITS-1:0] FREE_RUN_WORD = 8'h06;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } axi_resp_e;

    typedef struct packed {
        logic auto_go;
        logic done;
        logic start;
    } ctrl_state_t;

    function automatic logic [CTRL_BITS-1:0] pack_ctrl(ctrl_state_t s, logic idle, logic ready);
        logic [CTRL_BITS-1:0] w;
        w            = '0;
        w[START_BIT] = s.start;
        w[DONE_BIT]  = s.done;
        w[IDLE_BIT]  = idle;
        w[READY_BIT] = ready;
        w[AUTO_BIT]  = s.auto_go;
        return w;
    endfunction
endpackage

// File: rtl/tcl_wr_port.sv
module tcl_wr_port
    import tcl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                awvalid,
    output logic                awready,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    output logic                wr_go,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_strb,
    input  logic                wr_hit
);
    logic      aw_held, w_held;
    axi_resp_e resp_q;

    assign awready = !aw_held && !bvalid;
    assign wready  = !w_held && !bvalid;
    assign wr_go   = aw_held && w_held && !bvalid;
    assign bresp   = resp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b0;
            resp_q  <= RESP_OKAY;
            wr_addr <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                wr_addr <= awaddr;
            end
            if (wvalid && wready) begin
                w_held  <= 1'b1;
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
            if (wr_go) begin
                aw_held <= 1'b0;
                w_held  <= 1'b0;
                bvalid  <= 1'b1;
                resp_q  <= wr_hit ? RESP_OKAY : RESP_SLVERR;
            end
            if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    assert_bresp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid && $stable(bresp));
endmodule

// File: rtl/tcl_rd_port.sv
module tcl_rd_port
    import tcl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rd_go,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] reg_word
);
    axi_resp_e resp_q;

    assign arready = !rvalid;
    assign rd_go   = arvalid && arready;
    assign rd_addr = araddr;
    assign rresp   = resp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            resp_q <= RESP_OKAY;
        end else begin
            if (rd_go) begin
                rvalid <= 1'b1;
                rdata  <= rd_hit ? reg_word : '0;
                resp_q <= rd_hit ? RESP_OKAY : RESP_SLVERR;
            end
            if (rvalid && rready) begin
                rvalid <= 1'b0;
            end
        end
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));
endmodule

// File: rtl/tcl_ctrl_bits.sv
module tcl_ctrl_bits
    import tcl_pkg::*;
#(
    parameter bit FREE_RUN = 1'b0,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic                rd_clr,
    input  logic                core_done,
    input  logic                core_idle,
    input  logic                core_ready,
    output logic                core_start,
    output logic [DATA_W-1:0]   reg_word
);
    localparam int CTRL_LANE = START_BIT / 8;

    ctrl_state_t st;
    logic        lane_wr, set_start;

    assign lane_wr   = wr_en && wr_strb[CTRL_LANE];
    assign set_start = (lane_wr && wr_data[START_BIT]) || (st.auto_go && core_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (set_start) begin
                st.start <= 1'b1;
            end else if (st.start && core_ready) begin
                st.start <= 1'b0;
            end
            if (core_done) begin
                st.done <= 1'b1;
            end else if (rd_clr) begin
                st.done <= 1'b0;
            end
            if (lane_wr) begin
                st.auto_go <= wr_data[AUTO_BIT];
            end
        end
    end

    generate
        if (FREE_RUN) begin : g_free
            assign reg_word   = DATA_W'(FREE_RUN_WORD);
            assign core_start = !rst;
        end else begin : g_hshk
            assign reg_word   = DATA_W'(pack_ctrl(st, core_idle, core_ready));
            assign core_start = st.start;
        end
    endgenerate

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
        st.start && core_ready && !set_start |=> !st.start);
    assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
        core_done |=> st.done);
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        st.done && !rd_clr |=> st.done);
endmodule

// File: rtl/task_ctl_axil.sv
module task_ctl_axil
    import tcl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter bit FREE_RUN = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    input  logic                s_arvalid,
    output logic                s_arready,
    input  logic [ADDR_W-1:0]   s_araddr,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                core_start,
    input  logic                core_done,
    input  logic                core_idle,
    input  logic                core_ready
);
    localparam int WORD_LSB = $clog2(DATA_W / 8);

    function automatic logic maps_ctrl(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WORD_LSB] == '0;
    endfunction

    logic                wr_go, rd_go, wr_hit, rd_hit;
    logic [ADDR_W-1:0]   wr_addr, rd_addr;
    logic [DATA_W-1:0]   wr_data, reg_word;
    logic [DATA_W/8-1:0] wr_strb;

    assign wr_hit = maps_ctrl(wr_addr);
    assign rd_hit = maps_ctrl(rd_addr);

    tcl_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst(rst),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
        .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_hit(wr_hit)
    );

    tcl_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst),
        .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
        .rd_go(rd_go), .rd_addr(rd_addr), .rd_hit(rd_hit), .reg_word(reg_word)
    );

    tcl_ctrl_bits #(.FREE_RUN(FREE_RUN), .DATA_W(DATA_W)) u_bits (
        .clk(clk), .rst(rst),
        .wr_en(wr_go && wr_hit), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_clr(rd_go && rd_hit),
        .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready),
        .core_start(core_start), .reg_word(reg_word)
    );

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        s_rvalid |-> (s_rdata[6:4] == 3'b000) && (s_rdata[DATA_W-1:8] == '0));
    assert_err_data_zero_R9: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && (s_rresp == RESP_SLVERR) |-> s_rdata == '0);
    assert_free_word_R10: assert property (@(posedge clk) disable iff (rst)
        FREE_RUN && s_rvalid && (s_rresp == RESP_OKAY) |-> s_rdata == DATA_W'(FREE_RUN_WORD));
endmodule

// File: tb/tb_task_ctl_axil.sv
module tb_task_ctl_axil;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic [3:0]    s_wstrb = '0;
    logic          core_done = 0, core_idle = 1, core_ready = 0;

    logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid, core_start;
    logic [1:0]    s_bresp, s_rresp;
    logic [DW-1:0] s_rdata;
    logic          f_awready, f_wready, f_bvalid, f_arready, f_rvalid, f_start;
    logic [1:0]    f_bresp, f_rresp;
    logic [DW-1:0] f_rdata;

    task_ctl_axil #(.ADDR_W(AW), .DATA_W(DW), .FREE_RUN(1'b0)) dut (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready)
    );

    task_ctl_axil #(.ADDR_W(AW), .DATA_W(DW), .FREE_RUN(1'b1)) dut_free (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(f_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(f_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(f_bvalid), .s_bready(s_bready), .s_bresp(f_bresp),
        .s_arvalid(s_arvalid), .s_arready(f_arready), .s_araddr(s_araddr),
        .s_rvalid(f_rvalid), .s_rready(s_rready), .s_rdata(f_rdata), .s_rresp(f_rresp),
        .core_start(f_start), .core_done(core_done), .core_idle(core_idle), .core_ready(core_ready)
    );

    int checks = 0;
    int errors = 0;
    bit chk_en = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { logic [1:0] resp; logic [31:0] data; } rsp_t;
    rsp_t       rq[$];
    logic [1:0] bq[$];
    bit         m_start, m_done, m_auto, m_aw, m_w;
    logic [AW-1:0] m_awaddr;
    logic [31:0]   m_wdata;
    logic [3:0]    m_wstrb;

    always @(posedge clk) begin
        bit   wr_apply, wr_ok, rd_acc, rd_ok, lane, n_start, n_done, n_auto;
        rsp_t e;
        if (rst) begin
            m_start = 0; m_done = 0; m_auto = 0; m_aw = 0; m_w = 0;
            rq.delete(); bq.delete();
        end else begin
            wr_apply = !s_bvalid && m_aw && m_w;
            wr_ok    = (m_awaddr >> 2) == 0;
            lane     = wr_apply && wr_ok && m_wstrb[0];
            rd_acc   = s_arvalid && s_arready;
            rd_ok    = (s_araddr >> 2) == 0;
            n_start = m_start;
            if ((lane && m_wdata[0]) || (m_auto && core_done)) n_start = 1;
            else if (m_start && core_ready) n_start = 0;
            n_done = m_done;
            if (core_done) n_done = 1;
            else if (rd_acc && rd_ok) n_done = 0;
            n_auto = lane ? m_wdata[7] : m_auto;
            if (rd_acc) begin
                e.resp = rd_ok ? 2'b00 : 2'b10;
                e.data = rd_ok ? {24'h0, m_auto, 3'b000, core_ready, core_idle, m_done, m_start} : 32'h0;
                rq.push_back(e);
            end
            if (s_rvalid && s_rready && rq.size() > 0) void'(rq.pop_front());
            if (s_bvalid && s_bready && bq.size() > 0) void'(bq.pop_front());
            if (wr_apply) begin
                m_aw = 0; m_w = 0;
                bq.push_back(wr_ok ? 2'b00 : 2'b10);
            end
            if (s_awvalid && s_awready) begin m_aw = 1; m_awaddr = s_awaddr; end
            if (s_wvalid && s_wready) begin m_w = 1; m_wdata = s_wdata; m_wstrb = s_wstrb; end
            m_start = n_start; m_done = n_done; m_auto = n_auto;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            chk(core_start == m_start, "R4 core_start vs model", 32'(core_start), 32'(m_start));
            chk(f_start == 1'b1, "R10 free-run core_start", 32'(f_start), 32'h1);
            if (s_rvalid) begin
                chk(rq.size() > 0 && s_rdata == rq[0].data, "R2 rdata vs model", s_rdata,
                    rq.size() > 0 ? rq[0].data : 32'hx);
                chk(rq.size() > 0 && s_rresp == rq[0].resp, "R9 rresp vs model", 32'(s_rresp),
                    rq.size() > 0 ? 32'(rq[0].resp) : 32'hx);
            end
            if (f_rvalid && rq.size() > 0) begin
                chk(f_rdata == (rq[0].resp == 2'b00 ? 32'h6 : 32'h0), "R10 free-run rdata",
                    f_rdata, rq[0].resp == 2'b00 ? 32'h6 : 32'h0);
            end
            if (s_bvalid) begin
                chk(bq.size() > 0 && s_bresp == bq[0], "R8 bresp vs model", 32'(s_bresp),
                    bq.size() > 0 ? 32'(bq[0]) : 32'hx);
            end
        end
    end

    // ---------------- stimulus tasks (drive at negedge) ----------------
    task automatic hs(input bit do_aw, input bit do_w);
        bit a, w;
        s_awvalid = do_aw;
        s_wvalid  = do_w;
        while (s_awvalid || s_wvalid) begin
            a = s_awvalid && s_awready;
            w = s_wvalid && s_wready;
            @(negedge clk);
            if (a) s_awvalid = 0;
            if (w) s_wvalid = 0;
        end
    endtask

    task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] st,
                             input int order, input int stall, output logic [1:0] resp);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = st;
        if (order == 0) hs(1, 1);
        else if (order == 1) begin hs(1, 0); repeat (2) @(negedge clk); hs(0, 1); end
        else begin hs(0, 1); repeat (2) @(negedge clk); hs(1, 0); end
        while (!s_bvalid) @(negedge clk);
        resp = s_bresp;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(s_bvalid && s_bresp == resp, "R8 bvalid held", 32'(s_bvalid), 32'h1);
        end
        s_bready = 1;
        @(negedge clk);
        s_bready = 0;
        chk(!s_bvalid, "R8 single response", 32'(s_bvalid), 32'h0);
    endtask

    task automatic axi_read(input logic [AW-1:0] a, input int stall, input bit pulse_done,
                            output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1;
        if (pulse_done) core_done = 1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 0;
        core_done = 0;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata; resp = s_rresp;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(s_rvalid && s_rdata == d && s_rresp == resp, "R11 rdata held", s_rdata, d);
        end
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic pulse_done_only();
        @(negedge clk); core_done = 1;
        @(negedge clk); core_done = 0;
    endtask

    task automatic pulse_ready();
        @(negedge clk); core_ready = 1; core_idle = 0;
        @(negedge clk); core_ready = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1 sequence incomplete)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] d;
        logic [1:0]  r;
        repeat (3) @(negedge clk);
        chk(core_start == 0 && s_bvalid == 0 && s_rvalid == 0, "R1 outputs in reset",
            {29'h0, core_start, s_bvalid, s_rvalid}, 32'h0);
        rst = 0;
        @(negedge clk);
        chk_en = 1;
        chk(core_start == 0 && !s_bvalid && !s_rvalid, "R1 after reset", 32'(core_start), 32'h0);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h04 && r == 2'b00, "R1 R2 reset word idle only", d, 32'h04);

        axi_write(12'h000, 32'h1, 4'h1, 0, 0, r);
        chk(core_start == 1 && r == 2'b00, "R3 start set by write", 32'(core_start), 32'h1);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h05, "R3 start readback", d, 32'h05);
        axi_write(12'h000, 32'h0, 4'h1, 0, 0, r);
        chk(core_start == 1, "R3 writing zero keeps start", 32'(core_start), 32'h1);

        pulse_ready();
        chk(core_start == 0, "R4 start cleared by handshake", 32'(core_start), 32'h0);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h00, "R2 idle and ready low", d, 32'h00);

        core_idle = 1;
        pulse_done_only();
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h06, "R5 done visible", d, 32'h06);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h04, "R5 done cleared by read", d, 32'h04);

        axi_read(12'h000, 0, 1, d, r);
        chk(d == 32'h04, "R5 coincident read sees old done", d, 32'h04);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h06, "R5 set wins over clear", d, 32'h06);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h04, "R5 cleared afterwards", d, 32'h04);

        axi_write(12'h000, 32'h81, 4'h0, 0, 0, r);
        chk(core_start == 0, "R7 masked write start", 32'(core_start), 32'h0);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h04, "R7 masked write word", d, 32'h04);

        axi_write(12'h000, 32'h80, 4'h1, 1, 0, r);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h84, "R6 auto bit readback", d, 32'h84);
        pulse_done_only();
        chk(core_start == 1, "R6 auto relaunch sets start", 32'(core_start), 32'h1);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h87, "R6 word after relaunch", d, 32'h87);
        pulse_ready();
        core_idle = 1;
        axi_write(12'h000, 32'h0, 4'h1, 2, 3, r);
        chk(r == 2'b00, "R8 data-first write OKAY", 32'(r), 32'h0);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h04, "R8 auto cleared by data-first write", d, 32'h04);

        axi_write(12'h004, 32'h81, 4'hF, 0, 2, r);
        chk(r == 2'b10, "R9 unmapped write SLVERR", 32'(r), 32'h2);
        axi_read(12'h000, 0, 0, d, r);
        chk(d == 32'h04, "R9 unmapped write no effect", d, 32'h04);
        pulse_done_only();
        axi_read(12'h004, 0, 0, d, r);
        chk(d == 32'h0 && r == 2'b10, "R9 unmapped read", d, 32'h0);
        axi_read(12'h000, 3, 0, d, r);
        chk(d == 32'h06 && r == 2'b00, "R9 done survives unmapped read", d, 32'h06);

        axi_write(12'h000, 32'h81, 4'hF, 0, 0, r);
        @(negedge clk); s_araddr = 12'h000; s_arvalid = 1;
        while (!f_arready) @(negedge clk);
        @(negedge clk); s_arvalid = 0;
        while (!f_rvalid) @(negedge clk);
        chk(f_rdata == 32'h6 && f_rresp == 2'b00, "R10 free-run word after write", f_rdata, 32'h6);
        s_rready = 1; @(negedge clk); s_rready = 0;
        chk(f_start == 1, "R10 free-run start high", 32'(f_start), 32'h1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule